// File: doc/BRIEF.md
# Interrupt Event Ring Poster

This block appends interrupt event codes to a small circular queue that lives in a byte-wide shared memory. A producer raises a one-cycle post strobe with an 8-bit event code. The block then fetches the queue's head index and its pending-entry count from memory and picks the next free slot. It stores the code in that slot and writes the count back, one higher than before.

The queue holds 52 entries, so the slot number wraps at a depth that is not a power of two. Both the head index and the pending count are kept in memory, not in the block, so a consumer elsewhere can drain the queue by updating those two bytes. A post is dropped silently if the region-ready flag is low, and it is refused while an earlier post is still in progress. The queue region starts at a base address plus a fixed 64-byte stride for each client index. Both are elaboration parameters.

Top module: `irq_ring_writer`

## Requirements
- R1: After reset, and until a post is accepted, `busy_o`, `done_o`, `mem_rd_o` and `mem_wr_o` are all low.
- R2: A post with `region_ready_i` low is ignored: no memory read or write occurs and `busy_o` stays low.
- R3: A post strobe seen while `busy_o` is high is refused: the running sequence writes only its own code, and no further sequence starts.
- R4: In the first two cycles after an accepted post, the block reads the head index from byte offset 0 of the region and then the pending count from byte offset 1. Read data is returned one cycle after each read.
- R5: In the third cycle the event code is written to region offset 12 plus slot, where slot = (head + count) mod 52, for head and count each below 52.
- R6: In the fourth cycle the count byte (offset 1) is written with the count read in R4 plus one, modulo 256. Each post makes exactly two reads and two writes.
- R7: `busy_o` is high from the cycle after acceptance through the count-write cycle. `done_o` is high only in the count-write cycle, for exactly one cycle.
- R8: The region base address is BASE + CLIENT_ID * 64.
- R9: A memory read and a memory write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| post_valid_i | input | 1 | Post request strobe |
| post_code_i | input | 8 | Event code to enqueue |
| region_ready_i | input | 1 | Shared region has been set up |
| busy_o | output | 1 | Post sequence in progress |
| done_o | output | 1 | One-cycle pulse when the count write completes |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid one cycle after a read |

## Verification
The bench sweeps every pairing of head index and pending count below 52. This covers every wrap of the slot sum. A design that reduced the sum with a power-of-two mask, or compared against 51 instead of 52, would write the code into the wrong slot or beyond the entry area. Posts made while the region is not ready must cause no memory traffic at all; a design that only blocked the writes would still show reads. A second strobe injected mid-sequence would corrupt the entry code or add an extra write pair if a busy design failed to refuse it. The single-cycle `done_o` pulse is sampled on the cycle before it and the cycle after it, so off-by-one sequencing shows up.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_HEAD,
    ST_RD_CNT,
    ST_WR_ENT,
    ST_WR_CNT
  } ring_st_e;

  localparam int HEAD_OFS = 0;
  localparam int CNT_OFS  = 1;
endpackage

// File: rtl/irq_ring_slot.sv
module irq_ring_slot #(
  parameter int DEPTH = 52,
  parameter int IW    = 8
) (
  input  logic [IW-1:0] head_i,
  input  logic [IW-1:0] cnt_i,
  output logic [IW-1:0] slot_o
);
  localparam logic [IW:0] DEPTH_W = (IW+1)'(DEPTH);

  logic [IW:0] sum, red;

  always_comb begin
    sum    = {1'b0, head_i} + {1'b0, cnt_i};
    red    = sum - DEPTH_W;
    // single conditional subtract; operands kept below DEPTH by software
    slot_o = (sum >= DEPTH_W) ? red[IW-1:0] : sum[IW-1:0];
  end

  always_comb begin
    if (int'(head_i) < DEPTH && int'(cnt_i) < DEPTH)
      assert_slot_range_R5: assert (int'(slot_o) < DEPTH);
  end
endmodule

// File: rtl/irq_ring_seq.sv
module irq_ring_seq
  import irq_ring_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  output ring_st_e state_o
);
  ring_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_RD_HEAD;
      ST_RD_HEAD: state_d = ST_RD_CNT;
      ST_RD_CNT:  state_d = ST_WR_ENT;
      ST_WR_ENT:  state_d = ST_WR_CNT;
      ST_WR_CNT:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_start_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_RD_HEAD));
endmodule

// File: rtl/irq_ring_writer.sv
module irq_ring_writer
  import irq_ring_pkg::*;
#(
  parameter int AW        = 12,
  parameter int BASE      = 0,
  parameter int CLIENT_ID = 0,
  parameter int STRIDE    = 64,
  parameter int DEPTH     = 52,
  parameter int ENTRY_OFS = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          post_valid_i,
  input  logic [7:0]    post_code_i,
  input  logic          region_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i
);
  localparam logic [AW-1:0] REGION   = AW'(BASE + CLIENT_ID * STRIDE);
  localparam logic [AW-1:0] HEAD_ADR = REGION + AW'(HEAD_OFS);
  localparam logic [AW-1:0] CNT_ADR  = REGION + AW'(CNT_OFS);
  localparam logic [AW-1:0] ENT_ADR  = REGION + AW'(ENTRY_OFS);

  ring_st_e   state;
  logic       start;
  logic [7:0] head_q, cnt_q, code_q, slot;

  assign start = post_valid_i && region_ready_i && (state == ST_IDLE);

  irq_ring_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .state_o (state)
  );

  // count arrives on rdata during the entry-write cycle
  irq_ring_slot #(.DEPTH(DEPTH), .IW(8)) u_slot (
    .head_i (head_q),
    .cnt_i  (mem_rdata_i),
    .slot_o (slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      if (start)               code_q <= post_code_i;
      if (state == ST_RD_CNT)  head_q <= mem_rdata_i;
      if (state == ST_WR_ENT)  cnt_q  <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state)
      ST_RD_HEAD: begin mem_rd_o = 1'b1; mem_addr_o = HEAD_ADR; end
      ST_RD_CNT:  begin mem_rd_o = 1'b1; mem_addr_o = CNT_ADR;  end
      ST_WR_ENT: begin
        mem_wr_o    = 1'b1;
        mem_addr_o  = ENT_ADR + AW'(slot);
        mem_wdata_o = code_q;
      end
      ST_WR_CNT: begin
        mem_wr_o    = 1'b1;
        mem_addr_o  = CNT_ADR;
        mem_wdata_o = cnt_q + 8'd1;
      end
      default: ;
    endcase
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_WR_CNT);

  assert_no_rdwr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_rd_o && !mem_wr_o));
  assert_accept_head_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_valid_i && region_ready_i && !busy_o) |=> (mem_rd_o && mem_addr_o == HEAD_ADR));
  assert_drop_unready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!region_ready_i && !busy_o) |=> !busy_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_cnt_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && mem_addr_o != CNT_ADR) |=> (mem_wr_o && mem_addr_o == CNT_ADR && done_o));
endmodule

// File: tb/irq_ring_writer_tb.sv
module irq_ring_writer_tb;
  localparam int AW    = 10;
  localparam int BASE  = 256;
  localparam int CID   = 2;
  localparam int DEPTH = 52;
  localparam int REG   = BASE + CID * 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          post_valid = 1'b0;
  logic [7:0]    post_code = '0;
  logic          ready = 1'b0;
  logic          busy, done, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  logic          tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [7:0]    tb_data = '0;

  logic [7:0]    mem [1 << AW];
  int            n_rd = 0, n_wr = 0;
  int            rd_prev = 0, rd_last = 0;
  int            ent_addr = 0, ent_data = 0;
  int            n_chk = 0, n_fail = 0;
  int            cyc = 0;

  always #2 clk = ~clk;

  irq_ring_writer #(.AW(AW), .BASE(BASE), .CLIENT_ID(CID)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .post_valid_i   (post_valid),
    .post_code_i    (post_code),
    .region_ready_i (ready),
    .busy_o         (busy),
    .done_o         (done),
    .mem_rd_o       (mem_rd),
    .mem_wr_o       (mem_wr),
    .mem_addr_o     (mem_addr),
    .mem_wdata_o    (mem_wdata),
    .mem_rdata_i    (mem_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tb_we) mem[tb_addr] <= tb_data;
    if (mem_wr) begin
      mem[mem_addr] <= mem_wdata;
      n_wr <= n_wr + 1;
      if (int'(mem_addr) != REG + 1) begin
        ent_addr <= int'(mem_addr);
        ent_data <= int'(mem_wdata);
      end
    end
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr];
      n_rd      <= n_rd + 1;
      rd_prev   <= rd_last;
      rd_last   <= int'(mem_addr);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input int d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = AW'(a); tb_data = 8'(d);
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic do_post(input int h, input int c, input int code, input bit intrude);
    int s_rd, s_wr, exp_slot;
    poke(REG, h);
    poke(REG + 1, c);
    s_rd = n_rd; s_wr = n_wr;
    exp_slot = (h + c) % DEPTH;
    ready = 1'b1; post_valid = 1'b1; post_code = 8'(code);
    @(negedge clk);
    post_valid = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    @(negedge clk);
    if (intrude) begin post_valid = 1'b1; post_code = 8'(code ^ 8'hFF); end
    @(negedge clk);
    post_valid = 1'b0;
    check(done == 1'b0, "R7 done early", int'(done), 0);
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b1, "R7 done pulse", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7 back to idle", int'(busy), 0);
    check(rd_prev == REG && rd_last == REG + 1, "R4 R8 read order", rd_last, REG + 1);
    check(ent_addr == REG + 12 + exp_slot, "R5 slot address", ent_addr, REG + 12 + exp_slot);
    check(ent_data == (code & 255), "R5 R3 entry code", ent_data, code & 255);
    check(int'(mem[REG + 1]) == ((c + 1) & 255), "R6 count write", int'(mem[REG + 1]), (c + 1) & 255);
    check(n_wr - s_wr == 2 && n_rd - s_rd == 2, "R6 R3 access count", n_wr - s_wr, 2);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s_rd, s_wr;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && mem_rd == 0 && mem_wr == 0, "R1 reset quiet",
          int'({busy, done, mem_rd, mem_wr}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && mem_rd == 0 && mem_wr == 0, "R1 idle after reset", int'(busy), 0);

    // R2: region not ready
    poke(REG, 5); poke(REG + 1, 3);
    s_rd = n_rd; s_wr = n_wr;
    ready = 1'b0; post_valid = 1'b1; post_code = 8'h5A;
    @(negedge clk);
    post_valid = 1'b0;
    check(busy == 1'b0, "R2 busy stays low", int'(busy), 0);
    repeat (6) @(negedge clk);
    check(n_rd == s_rd && n_wr == s_wr, "R2 no memory access", n_rd + n_wr - s_rd - s_wr, 0);
    check(int'(mem[REG + 1]) == 3, "R2 count untouched", int'(mem[REG + 1]), 3);

    // R3: intruding strobe while busy
    do_post(10, 20, 8'hA5, 1'b1);
    do_post(51, 51, 8'h3C, 1'b1);

    // R5 exhaustive sweep of head and count
    for (int h = 0; h < DEPTH; h++)
      for (int c = 0; c < DEPTH; c++)
        do_post(h, c, (h * 7 + c * 13 + 1) & 255, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule